// File: doc/BRIEF.md
# Motor Run-State and Brake Controller

This block chooses the drive state of a three-phase motor from three control pins (brake request, spin direction and drive-off) plus a commanded speed. The brake and direction pins can each be replaced by a register-supplied value. The drive-off pin cannot be replaced. All three pins pass through a two-flop synchroniser. The block then runs one state machine. That machine drives a state code, a target-speed request for the speed loop, a phase-order flag for the commutation logic, a one-cycle restart pulse and per-phase high-side and low-side switch enables.

A brake request does not stop the motor at once. The block first asks the speed loop to slow down to a programmable brake threshold. It switches to braking only when the measured speed is at or below that threshold. Braking is either low-side (every low-side switch on) or align (phase A high side, the other phases low side). Drive-off puts the motor in coast from any state, with every switch off. The logic keeps running during drive-off. When drive-off is released, the block pulses restart and begins again from IDLE.

All interfaces are plain level signals. The block has no data stream and so has no valid/ready handshake.

Top module: `motor_runstate_ctrl`

## Requirements
- R1: Each pin goes through two synchronising flops before the state register. A pin change made before edge 1 changes the state at edge 3, and not earlier.
- R2: The state code is IDLE=0, RUN=1, DECEL_TO_BRAKE=2, BRAKE=3, COAST=4. After reset the block is in IDLE with target 0, all switch enables 0, restart 0 and phase flag 1.
- R3: IDLE goes to RUN when the commanded speed is nonzero. RUN goes to IDLE when the commanded speed is zero. In RUN the target equals the commanded speed.
- R4: A brake request in RUN moves the block to DECEL_TO_BRAKE, where the target equals the brake threshold.
- R5: DECEL_TO_BRAKE goes to BRAKE only when the measured speed is less than or equal to the threshold. The block stays in BRAKE while the brake request holds, and the target there is 0.
- R6: When the brake request is released, DECEL_TO_BRAKE and BRAKE both return to RUN.
- R7: In RUN and DECEL_TO_BRAKE both enable vectors are 3'b111. In IDLE and COAST both are 3'b000. In BRAKE with low-side braking, high = 3'b000 and low = 3'b111. In BRAKE with align braking (mode bit 1), high = 3'b001 and low = 3'b110. Bit 0 is phase A.
- R8: The phase flag follows the direction input only while the block is in IDLE or COAST. It holds in RUN, DECEL_TO_BRAKE and BRAKE. A flag of 1 means order A,B,C and 0 means A,C,B.
- R9: Drive-off high forces COAST from every state, with all enables 0 and target 0.
- R10: When drive-off is released in COAST, the block enters IDLE and raises restart for exactly one cycle.
- R11: When an override enable is 1, the override value replaces the synchronised brake or direction pin. The pin then has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| brake_pin | input | 1 | Brake request pin, asynchronous |
| dir_pin | input | 1 | Direction pin, asynchronous |
| drvoff_pin | input | 1 | Drive-off pin, asynchronous |
| brake_ovr_en | input | 1 | Use brake_ovr_val instead of the pin |
| brake_ovr_val | input | 1 | Register brake value |
| dir_ovr_en | input | 1 | Use dir_ovr_val instead of the pin |
| dir_ovr_val | input | 1 | Register direction value |
| brake_align | input | 1 | 1 = align braking, 0 = low-side braking |
| speed_cmd | input | SPD_W | Commanded speed |
| speed_meas | input | SPD_W | Measured speed |
| brake_thr | input | SPD_W | Brake speed threshold |
| drv_state | output | 3 | State code |
| speed_target | output | SPD_W | Target speed request |
| phase_fwd | output | 1 | Phase order flag |
| restart | output | 1 | One-cycle fresh-start pulse |
| hs_en | output | PHASES | High-side enables, bit 0 = phase A |
| ls_en | output | PHASES | Low-side enables, bit 0 = phase A |

## Verification
The state sequence is driven by a series of brake requests under three measured speeds. A speed above the threshold, one at the threshold and one just above it show that the entry condition is less-or-equal. One brake request is released during deceleration and another in BRAKE, which shows that both paths return to RUN without braking. Direction changes are applied once while the motor is driven and once in IDLE or COAST, which shows that the flag is latched only when idle or coasting. The override tests drive pin and register to opposite values, so that any result taken from the wrong source shows up. Drive-off is released while the bench counts edges, which pins down the synchroniser latency and the width of the restart pulse.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN   = 3'd1,
    ST_DECEL = 3'd2,
    ST_BRAKE = 3'd3,
    ST_COAST = 3'd4
  } drv_state_e;
endpackage

// File: rtl/mrs_sync.sv
module mrs_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/mrs_ovr_sel.sv
module mrs_ovr_sel (
  input  logic pin_s,
  input  logic ovr_en,
  input  logic ovr_val,
  output logic eff
);
  always_comb eff = ovr_en ? ovr_val : pin_s;
endmodule

// File: rtl/mrs_fsm.sv
module mrs_fsm
  import mrs_pkg::*;
#(
  parameter int SPD_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             brake,
  input  logic             dir,
  input  logic             drvoff,
  input  logic [SPD_W-1:0] speed_cmd,
  input  logic [SPD_W-1:0] speed_meas,
  input  logic [SPD_W-1:0] brake_thr,
  output drv_state_e       state,
  output logic             fwd,
  output logic             restart
);
  drv_state_e nxt;

  always_comb begin
    nxt = state;
    if (drvoff) nxt = ST_COAST;
    else begin
      unique case (state)
        ST_IDLE:  if (speed_cmd != '0) nxt = ST_RUN;
        ST_RUN:   if (brake) nxt = ST_DECEL;
                  else if (speed_cmd == '0) nxt = ST_IDLE;
        ST_DECEL: if (!brake) nxt = ST_RUN;
                  else if (speed_meas <= brake_thr) nxt = ST_BRAKE;
        ST_BRAKE: if (!brake) nxt = ST_RUN;
        ST_COAST: nxt = ST_IDLE;
        default:  nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      fwd     <= 1'b1;
      restart <= 1'b0;
    end else begin
      state   <= nxt;
      restart <= (state == ST_COAST) && !drvoff;
      if (state == ST_IDLE || state == ST_COAST) fwd <= dir;
    end
  end
endmodule

// File: rtl/mrs_out_dec.sv
module mrs_out_dec
  import mrs_pkg::*;
#(
  parameter int SPD_W  = 16,
  parameter int PHASES = 3
) (
  input  drv_state_e        state,
  input  logic              align,
  input  logic [SPD_W-1:0]  speed_cmd,
  input  logic [SPD_W-1:0]  brake_thr,
  output logic [SPD_W-1:0]  target,
  output logic [PHASES-1:0] hs_en,
  output logic [PHASES-1:0] ls_en
);
  logic driving, braking;
  always_comb begin
    driving = (state == ST_RUN) || (state == ST_DECEL);
    braking = (state == ST_BRAKE);
    case (state)
      ST_RUN:   target = speed_cmd;
      ST_DECEL: target = brake_thr;
      default:  target = '0;
    endcase
  end

  for (genvar i = 0; i < PHASES; i++) begin : g_ph
    localparam bit ALIGN_HI = (i == 0);
    always_comb begin
      hs_en[i] = driving || (braking && align && ALIGN_HI);
      ls_en[i] = driving || (braking && !(align && ALIGN_HI));
    end
  end
endmodule

// File: rtl/motor_runstate_ctrl.sv
module motor_runstate_ctrl
  import mrs_pkg::*;
#(
  parameter int SPD_W  = 16,
  parameter int PHASES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              brake_pin,
  input  logic              dir_pin,
  input  logic              drvoff_pin,
  input  logic              brake_ovr_en,
  input  logic              brake_ovr_val,
  input  logic              dir_ovr_en,
  input  logic              dir_ovr_val,
  input  logic              brake_align,
  input  logic [SPD_W-1:0]  speed_cmd,
  input  logic [SPD_W-1:0]  speed_meas,
  input  logic [SPD_W-1:0]  brake_thr,
  output logic [2:0]        drv_state,
  output logic [SPD_W-1:0]  speed_target,
  output logic              phase_fwd,
  output logic              restart,
  output logic [PHASES-1:0] hs_en,
  output logic [PHASES-1:0] ls_en
);
  localparam int NPIN = 3;
  logic [NPIN-1:0] pins_s;
  logic brake_eff, dir_eff;
  drv_state_e st;

  mrs_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({drvoff_pin, dir_pin, brake_pin}), .q(pins_s)
  );

  mrs_ovr_sel u_brk_sel (.pin_s(pins_s[0]), .ovr_en(brake_ovr_en),
                         .ovr_val(brake_ovr_val), .eff(brake_eff));
  mrs_ovr_sel u_dir_sel (.pin_s(pins_s[1]), .ovr_en(dir_ovr_en),
                         .ovr_val(dir_ovr_val), .eff(dir_eff));

  mrs_fsm #(.SPD_W(SPD_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .brake(brake_eff), .dir(dir_eff),
    .drvoff(pins_s[2]), .speed_cmd(speed_cmd), .speed_meas(speed_meas),
    .brake_thr(brake_thr), .state(st), .fwd(phase_fwd), .restart(restart)
  );

  mrs_out_dec #(.SPD_W(SPD_W), .PHASES(PHASES)) u_dec (
    .state(st), .align(brake_align), .speed_cmd(speed_cmd),
    .brake_thr(brake_thr), .target(speed_target), .hs_en(hs_en), .ls_en(ls_en)
  );

  assign drv_state = st;
endmodule

// File: rtl/motor_runstate_ctrl_chk.sv
module motor_runstate_ctrl_chk #(
  parameter int SPD_W  = 16,
  parameter int PHASES = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        drv_state,
  input logic [SPD_W-1:0]  speed_target,
  input logic [SPD_W-1:0]  speed_meas,
  input logic [SPD_W-1:0]  brake_thr,
  input logic              phase_fwd,
  input logic              restart,
  input logic [PHASES-1:0] hs_en,
  input logic [PHASES-1:0] ls_en
);
  localparam logic [2:0] S_IDLE = 3'd0, S_RUN = 3'd1, S_DECEL = 3'd2,
                         S_BRAKE = 3'd3, S_COAST = 3'd4;

  a_r9_coast_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    drv_state == S_COAST |-> (hs_en == '0 && ls_en == '0 && speed_target == '0));

  a_r10_restart_single: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !restart);

  a_r10_restart_after_coast: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restart) |-> ($past(drv_state) == S_COAST && drv_state == S_IDLE));

  a_r8_dir_held_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_state == S_RUN || drv_state == S_DECEL || drv_state == S_BRAKE)
    |=> $stable(phase_fwd));

  a_r5_brake_entry_speed: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_state == S_BRAKE && $past(drv_state) == S_DECEL)
    |-> $past(speed_meas <= brake_thr));

  a_r4_decel_target: assert property (@(posedge clk) disable iff (!rst_n)
    drv_state == S_DECEL |-> speed_target == brake_thr);

  a_r2_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    drv_state <= S_COAST);
endmodule

bind motor_runstate_ctrl motor_runstate_ctrl_chk #(.SPD_W(SPD_W), .PHASES(PHASES)) u_chk (
  .clk(clk), .rst_n(rst_n), .drv_state(drv_state), .speed_target(speed_target),
  .speed_meas(speed_meas), .brake_thr(brake_thr), .phase_fwd(phase_fwd),
  .restart(restart), .hs_en(hs_en), .ls_en(ls_en)
);

// File: tb/sim_motor_runstate_ctrl.sv
`timescale 1ns/1ps
module sim_motor_runstate_ctrl;
  localparam int SPD_W = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic brake_pin = 0, dir_pin = 1, drvoff_pin = 0;
  logic brake_ovr_en = 0, brake_ovr_val = 0, dir_ovr_en = 0, dir_ovr_val = 0, brake_align = 0;
  logic [SPD_W-1:0] speed_cmd = '0, speed_meas = '0, brake_thr = 16'd20;
  logic [2:0] drv_state;
  logic [SPD_W-1:0] speed_target;
  logic phase_fwd, restart;
  logic [2:0] hs_en, ls_en;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  motor_runstate_ctrl u0 (.*);

  typedef struct packed {
    logic brk, dir, off, be, bv, de, dv, al;
    logic [15:0] cmd, meas, thr;
    logic [2:0] st;
    logic [15:0] tgt;
    logic [2:0] hi, lo;
    logic fwd;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [0:NV-1] = '{
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'd0,  16'd0, 16'd20, 3'd0, 16'd0,   3'd0,3'd0,1'b1}, // R3 idle
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'd100,16'd0, 16'd20, 3'd1, 16'd100, 3'd7,3'd7,1'b1}, // R3 run
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'd100,16'd80,16'd20, 3'd2, 16'd20,  3'd7,3'd7,1'b1}, // R4 decel
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'd100,16'd20,16'd20, 3'd3, 16'd0,   3'd0,3'd7,1'b1}, // R5 equal thr
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'd100,16'd20,16'd20, 3'd1, 16'd100, 3'd7,3'd7,1'b1}, // R6 from brake
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'd100,16'd21,16'd20, 3'd2, 16'd20,  3'd7,3'd7,1'b1}, // R5 thr+1
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'd100,16'd21,16'd20, 3'd1, 16'd100, 3'd7,3'd7,1'b1}, // R6 from decel
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'd100,16'd21,16'd20, 3'd1, 16'd100, 3'd7,3'd7,1'b1}, // R8 held
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 16'd100,16'd10,16'd20, 3'd3, 16'd0,   3'd1,3'd6,1'b1}, // R7 align
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 16'd0,  16'd10,16'd20, 3'd0, 16'd0,   3'd0,3'd0,1'b0}, // R8 idle latch
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 16'd100,16'd5, 16'd20, 3'd3, 16'd0,   3'd0,3'd7,1'b0}, // R11 brake ovr on
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 16'd100,16'd5, 16'd20, 3'd1, 16'd100, 3'd7,3'd7,1'b0}, // R11 pin masked
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 16'd100,16'd5, 16'd20, 3'd1, 16'd100, 3'd7,3'd7,1'b0}, // R11 dir ovr held
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0, 16'd100,16'd5, 16'd20, 3'd4, 16'd0,   3'd0,3'd0,1'b1}, // R9 coast
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 16'd100,16'd5, 16'd20, 3'd1, 16'd100, 3'd7,3'd7,1'b1}  // R10 restart run
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    {brake_pin, dir_pin, drvoff_pin, brake_ovr_en, brake_ovr_val,
     dir_ovr_en, dir_ovr_val, brake_align} = {v.brk, v.dir, v.off, v.be, v.bv, v.de, v.dv, v.al};
    speed_cmd = v.cmd; speed_meas = v.meas; brake_thr = v.thr;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R2 reset state", drv_state, 0);
    chk("R2 reset fwd", phase_fwd, 1);
    chk("R2 reset enables", {hs_en, ls_en}, 0);
    chk("R2 reset restart", restart, 0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk) apply(TBL[i]);
      repeat (6) @(posedge clk);
      #1;
      chk($sformatf("row%0d state", i), drv_state, TBL[i].st);
      chk($sformatf("row%0d target", i), speed_target, TBL[i].tgt);
      chk($sformatf("row%0d hs_en R7", i), hs_en, TBL[i].hi);
      chk($sformatf("row%0d ls_en R7", i), ls_en, TBL[i].lo);
      chk($sformatf("row%0d fwd R8", i), phase_fwd, TBL[i].fwd);
    end

    // R9: drive-off wins over BRAKE
    @(negedge clk) begin brake_pin = 1; speed_meas = 16'd5; end
    repeat (6) @(posedge clk); #1;
    chk("R5 brake before drvoff", drv_state, 3);
    @(negedge clk) drvoff_pin = 1;
    repeat (6) @(posedge clk); #1;
    chk("R9 coast over brake", drv_state, 4);
    chk("R9 coast enables", {hs_en, ls_en}, 0);

    // R1/R10: exact latency and pulse width on release
    @(negedge clk) begin drvoff_pin = 0; brake_pin = 0; end
    repeat (2) @(posedge clk); #1;
    chk("R1 still coast after 2 edges", drv_state, 4);
    chk("R1 no early restart", restart, 0);
    @(posedge clk); #1;
    chk("R10 idle after release", drv_state, 0);
    chk("R10 restart high", restart, 1);
    @(posedge clk); #1;
    chk("R10 restart one cycle", restart, 0);
    chk("R3 run after restart", drv_state, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule